// File: doc/BRIEF.md
# Egress Timestamp Register Poller

This block fetches the egress timestamp that a switch port records for a transmitted frame. After a start pulse it reads that port's timestamp register through a generic read request/response channel. Bit 0 of the returned word is a ready flag. If the flag is clear, the block waits a programmable number of clock cycles and reads again. It gives up after a fixed number of reads. When the flag is set, it pulls the stamp out of the returned word using one of two layouts and reports it with a one-cycle done pulse. The serial transfer that serves each read sits outside this block.

Two layouts are supported. In the short layout the response is one 32-bit word and the stamp is 24 bits wide. In the long layout the response is 64 bits and the stamp is a full 32-bit word. An error signalled on the read channel ends the operation at once and is reported on its own line, apart from the timeout.

The controller moves through six named states. IDLE waits for a start pulse (transition *launch*). ISSUE holds the read request until the response arrives. From ISSUE there are four exits: *ready* to REPORT_OK, *fault* to REPORT_ERR, *exhausted* to REPORT_TMO, and *retry* to BACKOFF. BACKOFF counts the programmed delay down, then returns to ISSUE (transition *reissue*). Each REPORT state lasts one cycle and then returns to IDLE (transition *release*).

Top module: `egress_ts_poller`

## Requirements
- R1: After reset: rd_req_o, busy_o, done_o, timeout_o and error_o are 0, and ts_o is 0.
- R2: A start_i pulse in IDLE raises rd_req_o on the next cycle. rd_req_o stays high, with rd_port_o equal to the captured port_i and rd_long_o equal to the captured layout_i, until a cycle with rd_ack_i high. A start_i pulse while busy_o is 1 has no effect.
- R3: A response with rd_err_i=0 and data bit 0 set produces done_o=1 in the cycle after the acknowledge. After that, rd_req_o stays 0.
- R4: With layout_i=0 (short), ts_o carries data bits 31:8 in ts_o[23:0], and ts_o[31:24] is zero. Data bits 63:32 have no effect.
- R5: With layout_i=1 (long), ts_o equals data bits 63:32.
- R6: After a response with bit 0 clear, rd_req_o stays low for exactly delay_i+1 cycles before it rises again. The delay is captured at start.
- R7: If MAX_TRIES responses in a row all have bit 0 clear, timeout_o pulses in the cycle after the last acknowledge, and no further read is issued.
- R8: A response with rd_err_i=1 produces error_o=1 in the cycle after the acknowledge, whatever bit 0 holds. done_o stays 0 and no further read is issued.
- R9: Each operation ends with exactly one of done_o, timeout_o or error_o. busy_o is 1 from the cycle after start up to and including that report cycle, and 0 in the cycle after it.
- R10: ts_o changes only when done_o is reported. A timeout or an error leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll (acted on in IDLE only) |
| port_i | input | PORT_W | Port whose timestamp register is read |
| layout_i | input | 1 | 0: 4-byte word with 24-bit stamp, 1: 8-byte word with 32-bit stamp |
| delay_i | input | DLY_W | Retry delay; the gap between reads is delay_i+1 cycles |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_port_o | output | PORT_W | Port of the pending read |
| rd_long_o | output | 1 | Pending read is 8 bytes wide |
| rd_ack_i | input | 1 | Response valid |
| rd_err_i | input | 1 | Response carries a transfer error |
| rd_data_i | input | DATA_W | Response payload; bit 0 is the ready flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Stamp valid pulse |
| timeout_o | output | 1 | Retry budget used up |
| error_o | output | 1 | Read channel reported an error |
| ts_o | output | TS_W | Extracted timestamp, zero-extended |

## Verification
The bench uses the default parameters: MAX_TRIES of 10, an 8-bit delay, a 3-bit port and a 64-bit payload. It drives delays of 0, 1 and 2 cycles only. Because the delays are this short, every path can be reached in a few hundred cycles: the full ten-read timeout, a retry followed by success in each layout, and an error that arrives together with a set flag. The same small delays also make the gap between reads countable exactly.

// File: rtl/etp_pkg.sv
package etp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_BACKOFF,
        ST_REPORT_OK,
        ST_REPORT_TMO,
        ST_REPORT_ERR
    } etp_state_e;

    typedef enum logic {
        LAYOUT_SHORT = 1'b0,
        LAYOUT_LONG  = 1'b1
    } etp_layout_e;

    localparam int READY_BIT = 0;

endpackage

// File: rtl/etp_backoff_timer.sv
module etp_backoff_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    assert_backoff_countdown_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)
    ) else $error("backoff counter skipped a step");

endmodule

// File: rtl/etp_stamp_extract.sv
module etp_stamp_extract #(
    parameter int DATA_W  = 64,
    parameter int SHORT_W = 24,
    parameter int LONG_W  = 32,
    parameter int TS_W    = 32
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              long_i,
    output logic              ready_o,
    output logic [TS_W-1:0]   stamp_o
);
    localparam int SHORT_LSB = 32 - SHORT_W;
    localparam int LONG_LSB  = DATA_W - LONG_W;

    logic unused_gap_bits;
    assign unused_gap_bits = ^data_i[SHORT_LSB-1:1];

    assign ready_o = data_i[etp_pkg::READY_BIT];

    always_comb begin
        stamp_o = '0;
        if (long_i) begin
            stamp_o[LONG_W-1:0] = data_i[LONG_LSB +: LONG_W];
        end else begin
            stamp_o[SHORT_W-1:0] = data_i[SHORT_LSB +: SHORT_W];
        end
    end

    always_comb begin
        assert_short_zero_fill_R4: assert (long_i || stamp_o[TS_W-1:SHORT_W] == '0)
            else $error("short stamp upper bits not zero");
    end

endmodule

// File: rtl/egress_ts_poller.sv
module egress_ts_poller #(
    parameter int PORT_W    = 3,
    parameter int DLY_W     = 8,
    parameter int MAX_TRIES = 10,
    parameter int DATA_W    = 64,
    parameter int TS_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              layout_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              rd_req_o,
    output logic [PORT_W-1:0] rd_port_o,
    output logic              rd_long_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              error_o,
    output logic [TS_W-1:0]   ts_o
);
    import etp_pkg::*;

    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

    etp_state_e state_q, state_d;

    logic [PORT_W-1:0] port_q;
    logic              long_q;
    logic [DLY_W-1:0]  delay_q;
    logic [TRY_W-1:0]  tries_q;
    logic [TS_W-1:0]   ts_q;

    logic              ready;
    logic [TS_W-1:0]   stamp;
    logic              timer_load;
    logic              timer_expired;

    etp_stamp_extract #(
        .DATA_W (DATA_W),
        .SHORT_W(24),
        .LONG_W (32),
        .TS_W   (TS_W)
    ) u_extract (
        .data_i (rd_data_i),
        .long_i (long_q),
        .ready_o(ready),
        .stamp_o(stamp)
    );

    etp_backoff_timer #(
        .CNT_W(DLY_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .load_val_i(delay_q),
        .expired_o (timer_expired)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ISSUE;                  // launch
            end
            ST_ISSUE: begin
                if (rd_ack_i) begin
                    if (rd_err_i)                state_d = ST_REPORT_ERR;  // fault
                    else if (ready)              state_d = ST_REPORT_OK;   // ready
                    else if (tries_q == LAST_TRY) state_d = ST_REPORT_TMO; // exhausted
                    else                         state_d = ST_BACKOFF;     // retry
                end
            end
            ST_BACKOFF: begin
                if (timer_expired) state_d = ST_ISSUE;            // reissue
            end
            ST_REPORT_OK,
            ST_REPORT_TMO,
            ST_REPORT_ERR: state_d = ST_IDLE;                     // release
            default: state_d = ST_IDLE;
        endcase
    end

    assign timer_load = (state_q == ST_ISSUE) && (state_d == ST_BACKOFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q  <= '0;
            long_q  <= LAYOUT_SHORT;
            delay_q <= '0;
            tries_q <= '0;
            ts_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                port_q  <= port_i;
                long_q  <= layout_i;
                delay_q <= delay_i;
                tries_q <= '0;
            end
            if (state_q == ST_ISSUE && rd_ack_i) begin
                tries_q <= tries_q + 1'b1;
                if (!rd_err_i && ready) ts_q <= stamp;
            end
        end
    end

    // output decode
    always_comb begin
        rd_req_o  = (state_q == ST_ISSUE);
        rd_port_o = port_q;
        rd_long_o = long_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_REPORT_OK);
        timeout_o = (state_q == ST_REPORT_TMO);
        error_o   = (state_q == ST_REPORT_ERR);
        ts_o      = ts_q;
    end

    assert_single_outcome_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, timeout_o, error_o})
    ) else $error("more than one outcome raised");

    assert_req_hold_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_port_o) && $stable(rd_long_o))
    ) else $error("read request dropped before acknowledge");

    assert_done_cause_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_ack_i && !rd_err_i && rd_data_i[READY_BIT])
    ) else $error("done without a ready response");

    assert_timeout_cause_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        timeout_o |-> $past(rd_ack_i && !rd_err_i && !rd_data_i[READY_BIT])
    ) else $error("timeout without a not-ready response");

    assert_error_cause_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        error_o |-> $past(rd_ack_i && rd_err_i)
    ) else $error("error without an erroneous response");

    assert_ts_hold_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ts_o)
    ) else $error("timestamp changed outside done");

endmodule

// File: tb/egress_ts_poller_bench.sv
module egress_ts_poller_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  port_i = '0;
    logic        layout_i = 1'b0;
    logic [7:0]  delay_i = '0;
    logic        rd_req_o;
    logic [2:0]  rd_port_o;
    logic        rd_long_o;
    logic        rd_ack_i = 1'b0;
    logic        rd_err_i = 1'b0;
    logic [63:0] rd_data_i = '0;
    logic        busy_o, done_o, timeout_o, error_o;
    logic [31:0] ts_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    egress_ts_poller u_egress_ts_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .port_i(port_i),
        .layout_i(layout_i), .delay_i(delay_i), .rd_req_o(rd_req_o),
        .rd_port_o(rd_port_o), .rd_long_o(rd_long_o), .rd_ack_i(rd_ack_i),
        .rd_err_i(rd_err_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o), .error_o(error_o), .ts_o(ts_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic kick(input logic [2:0] p, input logic lay, input logic [7:0] d);
        @(negedge clk);
        start_i = 1'b1; port_i = p; layout_i = lay; delay_i = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // waits for a request, returns the number of low cycles seen, answers after lat cycles
    task automatic serve(input logic [63:0] d, input logic e, input int lat, output int gap);
        gap = 0;
        while (!rd_req_o) begin
            gap++;
            @(negedge clk);
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(rd_req_o, "R2 request held", rd_req_o, 1);
        end
        rd_ack_i = 1'b1; rd_err_i = e; rd_data_i = d;
        @(negedge clk);
        rd_ack_i = 1'b0; rd_err_i = 1'b0; rd_data_i = '0;
    endtask

    task automatic expect_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!rd_req_o && !busy_o, req, {rd_req_o, busy_o}, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rd_req_o && !busy_o, "R1 idle after reset", {rd_req_o, busy_o}, 0);
        chk(!done_o && !timeout_o && !error_o, "R1 outcomes low", {done_o, timeout_o, error_o}, 0);
        chk(ts_o == 0, "R1 ts zero", ts_o, 0);
    endtask

    task automatic t_short_ok();
        int g;
        kick(3'd3, 1'b0, 8'd2);
        chk(rd_req_o && rd_port_o == 3 && !rd_long_o, "R2 request port/layout",
            {rd_req_o, rd_port_o, rd_long_o}, {1'b1, 3'd3, 1'b0});
        serve(64'hFFFF_FFFF_0000_1100, 1'b0, 1, g);
        chk(busy_o && !done_o, "R6 no report on clear flag", {busy_o, done_o}, 2'b10);
        serve(64'hFFFF_FFFF_0000_1100, 1'b0, 0, g);
        chk(g == 3, "R6 gap delay2", g, 3);
        serve(64'h1234_5678_ABCD_EF01, 1'b0, 0, g);
        chk(g == 3, "R6 second gap delay2", g, 3);
        chk(done_o && !timeout_o && !error_o, "R3 done pulse", {done_o, timeout_o, error_o}, 3'b100);
        chk(ts_o == 32'h00AB_CDEF, "R4 short stamp", ts_o, 32'h00AB_CDEF);
        chk(busy_o, "R9 busy in report cycle", busy_o, 1);
        @(negedge clk);
        chk(!busy_o && !done_o, "R9 release after report", {busy_o, done_o}, 0);
        expect_quiet("R3 polling stops", 3);
    endtask

    task automatic t_long_ok();
        int g;
        kick(3'd5, 1'b1, 8'd0);
        chk(rd_long_o && rd_port_o == 5, "R2 long request", {rd_long_o, rd_port_o}, {1'b1, 3'd5});
        @(negedge clk);
        start_i = 1'b1; port_i = 3'd1; layout_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_req_o && rd_port_o == 5 && rd_long_o, "R2 start ignored while busy",
            {rd_req_o, rd_port_o, rd_long_o}, {1'b1, 3'd5, 1'b1});
        serve(64'h0000_0000_FFFF_FFFE, 1'b0, 0, g);
        serve(64'hDEAD_BEEF_0000_0001, 1'b0, 0, g);
        chk(g == 1, "R6 gap delay0", g, 1);
        chk(done_o, "R3 done long", done_o, 1);
        chk(ts_o == 32'hDEAD_BEEF, "R5 long stamp", ts_o, 32'hDEAD_BEEF);
        expect_quiet("R3 long polling stops", 3);
    endtask

    task automatic t_timeout();
        int g;
        int reads = 0;
        kick(3'd2, 1'b0, 8'd1);
        for (int i = 0; i < 10; i++) begin
            serve(64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 0, g);
            reads++;
            if (i > 0) chk(g == 2, "R6 gap delay1", g, 2);
            if (i < 9) chk(!timeout_o, "R7 no early timeout", timeout_o, 0);
        end
        chk(timeout_o && !done_o && !error_o, "R7 timeout pulse", {done_o, timeout_o, error_o}, 3'b010);
        chk(ts_o == 32'hDEAD_BEEF, "R10 ts kept on timeout", ts_o, 32'hDEAD_BEEF);
        chk(reads == 10, "R7 read count", reads, 10);
        expect_quiet("R7 no read after timeout", 5);
    endtask

    task automatic t_error();
        int g;
        kick(3'd6, 1'b1, 8'd0);
        serve(64'h0000_0000_0000_0000, 1'b0, 0, g);
        serve(64'h1111_2222_0000_0001, 1'b1, 2, g);
        chk(error_o && !done_o && !timeout_o, "R8 error pulse", {done_o, timeout_o, error_o}, 3'b001);
        chk(ts_o == 32'hDEAD_BEEF, "R10 ts kept on error", ts_o, 32'hDEAD_BEEF);
        expect_quiet("R8 abort after error", 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short_ok();
        t_long_ok();
        t_timeout();
        t_error();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
    end

endmodule